// File: doc/BRIEF.md
# Burst Frame Regenerator

This block rebuilds an on-off keyed burst train from a frame of twelve 9-bit counts. The counts arrive one at a time over a ready/valid stream. They alternate between a burst length and the quiet gap that follows it, so a frame holds six bursts and six gaps. Each count is a number of carrier periods, and one carrier period is `CLK_DIV` system clocks. With the default settings, a 10.24 MHz clock yields a 2.56 MHz carrier.

The block stores and checks the whole frame before it plays anything. It rejects a frame if any timed entry is zero, or if the timed entries add up to more than one frame slot. An accepted frame waits for the next slot boundary, which comes every `SLOT_CLKS` clocks (400 µs by default). It then drives a gate that is high during bursts and low during gaps. The burst output is that gate ANDed with the carrier.

The last gap of a frame is never timed. After the sixth burst the block becomes free again, and playback of the next frame waits for the next slot boundary.

Top module: `frame_regen`

## Requirements
- R1: Entries are taken in arrival order. Entries 0, 2, 4, 6, 8 and 10 are bursts, during which gate is high. Entries 1, 3, 5, 7 and 9 are gaps, during which gate is low. An entry with count c lasts exactly c*CLK_DIV clocks, and the entries play back to back.
- R2: in_ready is high only while no frame is stored, being checked or playing. A word is taken on a clock where in_valid and in_ready are both high. While in_ready is low, in_valid and in_data have no effect, including on the contents of the next frame.
- R3: After the twelfth word is taken, in_ready is low for exactly one check cycle. It stays low afterwards if the frame is kept.
- R4: A frame is rejected if any of entries 0 to 10 is zero. Entry 11, the final gap, is not checked and does not affect playback.
- R5: A frame is rejected if the sum of entries 0 to 10 exceeds SLOT_CLKS/CLK_DIV, which is 1024 by default. A sum exactly equal to that limit is accepted and plays completely.
- R6: A kept frame starts playback only in a cycle whose index since reset release is a multiple of SLOT_CLKS. Cycle 0 is the first cycle after reset release. Gate rises in that cycle.
- R7: carrier is high in the first CLK_DIV/2 clocks of every CLK_DIV-clock period, with periods aligned to cycle 0. With OUT_REG=0, burst equals gate AND carrier.
- R8: busy is high from the first burst cycle through the last cycle of the sixth burst. Gate changes only at carrier period boundaries. in_ready returns in the cycle after the sixth burst ends.
- R9: A rejected frame produces no gate and no busy. in_ready returns in the cycle after the check.
- R10: During and right after reset, in_ready is high and busy, gate and burst are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_data | input | CNT_W | Count in carrier periods |
| in_ready | output | 1 | Block can take a word |
| busy | output | 1 | A frame is playing |
| gate | output | 1 | Burst envelope |
| carrier | output | 1 | Clock divided by CLK_DIV |
| burst | output | 1 | Gate ANDed with carrier |

## Verification
The main pattern is a short frame with uneven counts. It separates correct entry ordering and per-entry length from off-by-one counter errors. A frame that fills the slot exactly, and another that exceeds it by one carrier period, pin down where the length limit sits. Frames with a zero burst, a zero gap and a zero final gap show which entries are checked. A frame that mixes maximum and minimum counts with gaps in valid, followed by valid held high while the block is busy, shows that only accepted words reach the buffer.

// File: rtl/regen_pkg.sv
package regen_pkg;
   typedef enum logic [1:0] {
      ST_FILL  = 2'd0,
      ST_CHECK = 2'd1,
      ST_HOLD  = 2'd2
   } store_st_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/regen_timebase.sv
module regen_timebase #(
   parameter int CLK_DIV   = 4,
   parameter int SLOT_CLKS = 4096
) (
   input  logic clk,
   input  logic rst,
   output logic carrier_o,
   output logic ctick_o,
   output logic slot_last_o
);
   localparam int PH_W   = $clog2(CLK_DIV);
   localparam int SLOT_W = $clog2(SLOT_CLKS);

   logic [PH_W-1:0]   ph_q;
   logic [SLOT_W-1:0] slot_q;

   assign ctick_o     = (ph_q == PH_W'(CLK_DIV - 1));
   assign carrier_o   = (ph_q < PH_W'(CLK_DIV / 2));
   assign slot_last_o = (slot_q == SLOT_W'(SLOT_CLKS - 1));

   generate
      if (regen_pkg::is_pow2(CLK_DIV)) begin : g_ph_wrap
         always_ff @(posedge clk)
            if (rst) ph_q <= '0;
            else     ph_q <= ph_q + 1'b1;
      end else begin : g_ph_mod
         always_ff @(posedge clk)
            if (rst)          ph_q <= '0;
            else if (ctick_o) ph_q <= '0;
            else              ph_q <= ph_q + 1'b1;
      end
      if (regen_pkg::is_pow2(SLOT_CLKS)) begin : g_slot_wrap
         always_ff @(posedge clk)
            if (rst) slot_q <= '0;
            else     slot_q <= slot_q + 1'b1;
      end else begin : g_slot_mod
         always_ff @(posedge clk)
            if (rst)              slot_q <= '0;
            else if (slot_last_o) slot_q <= '0;
            else                  slot_q <= slot_q + 1'b1;
      end
   endgenerate

   // R6: a slot boundary is always also a carrier boundary
   a_r6_slot_on_carrier : assert property (@(posedge clk) disable iff (rst)
      slot_last_o |-> ctick_o);
endmodule

// File: rtl/regen_store.sv
module regen_store import regen_pkg::*; #(
   parameter int CNT_W   = 9,
   parameter int N_PAIRS = 6,
   parameter int LIMIT   = 1024
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [CNT_W-1:0]             in_data,
   input  logic                         release_i,
   output logic                         in_ready,
   output logic                         full_o,
   output logic [2*N_PAIRS*CNT_W-1:0]   frame_o
);
   localparam int N_ENT   = 2 * N_PAIRS;
   localparam int N_TIMED = N_ENT - 1;
   localparam int IDX_W   = $clog2(N_ENT);
   localparam int SUM_W   = $clog2(N_TIMED) + CNT_W + 1;

   store_st_t         st_q;
   logic [IDX_W-1:0]  wr_q;
   logic [CNT_W-1:0]  mem_q [N_ENT];
   logic [N_TIMED-1:0] zero_w;
   logic [SUM_W-1:0]  sum_w;
   logic              take_w, frame_ok_w;

   assign in_ready = (st_q == ST_FILL);
   assign full_o   = (st_q == ST_HOLD);
   assign take_w   = in_valid && in_ready;

   genvar g;
   generate
      for (g = 0; g < N_ENT; g++) begin : g_ent
         assign frame_o[g*CNT_W +: CNT_W] = mem_q[g];
         if (g < N_TIMED) begin : g_zero
            assign zero_w[g] = (mem_q[g] == '0);
         end
      end
   endgenerate

   always_comb begin
      sum_w = '0;
      for (int i = 0; i < N_TIMED; i++) sum_w = sum_w + SUM_W'(mem_q[i]);
   end
   assign frame_ok_w = !(|zero_w) && (sum_w <= SUM_W'(LIMIT));

   always_ff @(posedge clk)
      if (take_w) mem_q[wr_q] <= in_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_FILL;
         wr_q <= '0;
      end else begin
         unique case (st_q)
            ST_FILL: if (take_w) begin
               if (wr_q == IDX_W'(N_ENT - 1)) begin
                  wr_q <= '0;
                  st_q <= ST_CHECK;
               end else begin
                  wr_q <= wr_q + 1'b1;
               end
            end
            ST_CHECK: st_q <= frame_ok_w ? ST_HOLD : ST_FILL;
            ST_HOLD:  if (release_i) st_q <= ST_FILL;
            default:  st_q <= ST_FILL;
         endcase
      end
   end

   a_r3_last_word_checks : assert property (@(posedge clk) disable iff (rst)
      (take_w && wr_q == IDX_W'(N_ENT - 1)) |=> (st_q == ST_CHECK));
   a_r3_check_one_cycle : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_CHECK) |=> (st_q != ST_CHECK));
   a_r2_hold_until_release : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_HOLD && !release_i) |=> (st_q == ST_HOLD));
endmodule

// File: rtl/regen_player.sv
module regen_player #(
   parameter int CNT_W   = 9,
   parameter int N_PAIRS = 6
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       ctick_i,
   input  logic                       slot_last_i,
   input  logic                       full_i,
   input  logic [2*N_PAIRS*CNT_W-1:0] frame_i,
   output logic                       gate_o,
   output logic                       busy_o,
   output logic                       done_o
);
   localparam int N_ENT   = 2 * N_PAIRS;
   localparam int N_TIMED = N_ENT - 1;
   localparam int IDX_W   = $clog2(N_ENT);

   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] rem_q, nxt_w;
   logic             gate_q, busy_q, step_w;

   assign step_w = busy_q && ctick_i && (rem_q == CNT_W'(1));
   assign done_o = step_w && (idx_q == IDX_W'(N_TIMED - 1));
   assign gate_o = gate_q;
   assign busy_o = busy_q;

   always_comb begin
      nxt_w = '0;
      for (int i = 0; i < N_TIMED - 1; i++)
         if (idx_q == IDX_W'(i)) nxt_w = frame_i[(i+1)*CNT_W +: CNT_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q  <= '0;
         rem_q  <= '0;
         gate_q <= 1'b0;
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         if (full_i && slot_last_i) begin
            busy_q <= 1'b1;
            gate_q <= 1'b1;
            idx_q  <= '0;
            rem_q  <= frame_i[CNT_W-1:0];
         end
      end else if (ctick_i) begin
         if (done_o) begin
            busy_q <= 1'b0;
            gate_q <= 1'b0;
         end else if (step_w) begin
            idx_q  <= idx_q + 1'b1;
            rem_q  <= nxt_w;
            gate_q <= ~gate_q;
         end else begin
            rem_q  <= rem_q - 1'b1;
         end
      end
   end

   a_r6_start_on_slot : assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q) |-> $past(slot_last_i));
   a_r8_edge_on_boundary : assert property (@(posedge clk) disable iff (rst)
      !$stable(gate_q) |-> $past(ctick_i));
   a_r8_gate_within_busy : assert property (@(posedge clk) disable iff (rst)
      gate_q |-> busy_q);
   a_r4_no_zero_entry : assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (rem_q != '0));
endmodule

// File: rtl/frame_regen.sv
module frame_regen #(
   parameter int CNT_W     = 9,
   parameter int N_PAIRS   = 6,
   parameter int CLK_DIV   = 4,
   parameter int SLOT_CLKS = 4096,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] in_data,
   output logic             in_ready,
   output logic             busy,
   output logic             gate,
   output logic             carrier,
   output logic             burst
);
   localparam int N_ENT      = 2 * N_PAIRS;
   localparam int SLOT_CARR  = SLOT_CLKS / CLK_DIV;

   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("CLK_DIV must be at least 2");
      end
      if (SLOT_CLKS % CLK_DIV != 0) begin : g_bad_slot
         $error("SLOT_CLKS must be a multiple of CLK_DIV");
      end
      if (N_PAIRS < 1 || CNT_W < 2) begin : g_bad_size
         $error("N_PAIRS and CNT_W too small");
      end
   endgenerate

   logic                   ctick, slot_last, full, done;
   logic [N_ENT*CNT_W-1:0] frame;

   regen_timebase #(.CLK_DIV(CLK_DIV), .SLOT_CLKS(SLOT_CLKS)) tb_i (
      .clk(clk), .rst(rst), .carrier_o(carrier), .ctick_o(ctick),
      .slot_last_o(slot_last));

   regen_store #(.CNT_W(CNT_W), .N_PAIRS(N_PAIRS), .LIMIT(SLOT_CARR)) st_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .release_i(done), .in_ready(in_ready), .full_o(full), .frame_o(frame));

   regen_player #(.CNT_W(CNT_W), .N_PAIRS(N_PAIRS)) pl_i (
      .clk(clk), .rst(rst), .ctick_i(ctick), .slot_last_i(slot_last),
      .full_i(full), .frame_i(frame), .gate_o(gate), .busy_o(busy),
      .done_o(done));

   generate
      if (OUT_REG) begin : g_out_reg
         logic burst_q;
         always_ff @(posedge clk)
            if (rst) burst_q <= 1'b0;
            else     burst_q <= gate & carrier;
         assign burst = burst_q;
      end else begin : g_out_comb
         assign burst = gate & carrier;
      end
   endgenerate

   a_r2_no_ready_while_busy : assert property (@(posedge clk) disable iff (rst)
      busy |-> !in_ready);
   a_r8_ready_after_done : assert property (@(posedge clk) disable iff (rst)
      done |=> (in_ready && !busy));
endmodule

// File: tb/frame_regen_tb_top.sv
module frame_regen_tb_top;
   localparam int SLOT = 4096;
   localparam int DIV  = 4;
   localparam int LIM  = SLOT / DIV;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [8:0] in_data = '0;
   logic       in_ready, busy, gate, carrier, burst;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   frame_regen dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .busy(busy), .gate(gate), .carrier(carrier),
      .burst(burst));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   int n = 0;
   int m_st = 0;
   int q[$];
   int mf[12];
   int m_start = 0, m_end = 0;

   always @(posedge clk) begin
      if (rst) begin
         n = 0; m_st = 0; q.delete();
      end else begin
         case (m_st)
            0: if (in_valid) begin
                  q.push_back(int'(in_data));
                  if (q.size() == 12) m_st = 1;
               end
            1: begin
                  int tot; bit zero;
                  tot = 0; zero = 0;
                  for (int k = 0; k < 11; k++) begin
                     tot += q[k];
                     if (q[k] == 0) zero = 1;
                  end
                  if (!zero && tot <= LIM) begin
                     for (int k = 0; k < 12; k++) mf[k] = q[k];
                     m_st = 2;
                  end else m_st = 0;
                  q.delete();
               end
            2: if (n % SLOT == SLOT - 1) begin
                  int tot;
                  tot = 0;
                  for (int k = 0; k < 11; k++) tot += mf[k];
                  m_st = 3; m_start = n + 1; m_end = m_start + DIV * tot;
               end
            3: if (n + 1 == m_end) m_st = 0;
            default: m_st = 0;
         endcase
         n++;
      end
   end

   function automatic bit exp_gate(input int m);
      int o, cum;
      if (m_st != 3) return 0;
      o = (m - m_start) / DIV;
      cum = 0;
      for (int k = 0; k < 11; k++) begin
         if (o < cum + mf[k]) return (k % 2 == 0);
         cum += mf[k];
      end
      return 0;
   endfunction

   int gate_cnt = 0, busy_cnt = 0, first_busy = -1;
   bit busy_prev = 0;

   always @(negedge clk) begin
      if (!rst) begin
         bit eg, ec;
         eg = exp_gate(n);
         ec = (n % DIV) < DIV / 2;
         check(in_ready == (m_st == 0), "R2", "in_ready", in_ready, m_st == 0);
         check(busy == (m_st == 3), "R8", "busy", busy, m_st == 3);
         check(gate == eg, "R1", "gate", gate, eg);
         check(carrier == ec, "R7", "carrier", carrier, ec);
         check(burst == (eg && ec), "R7", "burst", burst, eg && ec);
         if (gate) gate_cnt++;
         if (busy) busy_cnt++;
         if (busy && !busy_prev) first_busy = n;
         busy_prev = busy;
      end
   end

   int fr[12];

   task automatic send_frame(input bit gaps);
      for (int i = 0; i < 12; i++) begin
         if (gaps && (i % 2 == 1)) begin
            in_valid = 0;
            @(negedge clk);
         end
         in_valid = 1;
         in_data  = 9'(fr[i]);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 0;
   endtask

   task automatic wait_idle();
      while (m_st != 0) @(negedge clk);
   endtask

   task automatic clear_counts();
      gate_cnt = 0; busy_cnt = 0; first_busy = -1;
   endtask

   task automatic set_frame(input int a0, a1, a2, a3, a4, a5,
                            input int a6, a7, a8, a9, a10, a11);
      fr[0] = a0; fr[1] = a1; fr[2] = a2; fr[3] = a3; fr[4] = a4; fr[5] = a5;
      fr[6] = a6; fr[7] = a7; fr[8] = a8; fr[9] = a9; fr[10] = a10; fr[11] = a11;
   endtask

   task automatic expect_reject(input string req);
      clear_counts();
      send_frame(0);
      @(negedge clk);
      check(in_ready == 1, "R9", "ready after check", in_ready, 1);
      repeat (SLOT + 16) @(negedge clk);
      check(busy_cnt == 0, req, "busy cycles of rejected frame", busy_cnt, 0);
      check(gate_cnt == 0, "R9", "gate cycles of rejected frame", gate_cnt, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(in_ready == 1, "R10", "in_ready in reset", in_ready, 1);
      check(busy == 0, "R10", "busy in reset", busy, 0);
      check(gate == 0 && burst == 0, "R10", "gate|burst in reset", gate | burst, 0);
      rst = 0;
      @(negedge clk);

      // short uneven frame: R1, R6, R8
      set_frame(1, 2, 3, 1, 2, 6, 1, 3, 5, 2, 4, 300);
      clear_counts();
      send_frame(0);
      @(negedge clk);
      check(in_ready == 0, "R3", "ready held after check", in_ready, 0);
      wait_idle();
      check(gate_cnt == 4 * 16, "R1", "gate high cycles", gate_cnt, 64);
      check(busy_cnt == 4 * 30, "R8", "busy cycles", busy_cnt, 120);
      check(first_busy % SLOT == 0, "R6", "start cycle mod slot", first_busy % SLOT, 0);
      check(in_ready == 1, "R8", "ready after playback", in_ready, 1);

      // exact slot length, zero final gap: R5, R4
      set_frame(100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 24, 0);
      clear_counts();
      send_frame(0);
      wait_idle();
      check(busy_cnt == SLOT, "R5", "busy cycles full slot", busy_cnt, SLOT);
      check(gate_cnt == 4 * 524, "R4", "gate cycles with zero final gap", gate_cnt, 2096);

      // one carrier over the limit
      set_frame(100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 25, 5);
      expect_reject("R5");
      // zero burst
      set_frame(3, 3, 3, 3, 0, 3, 3, 3, 3, 3, 3, 3);
      expect_reject("R4");
      // zero timed gap
      set_frame(3, 3, 3, 3, 3, 3, 3, 3, 3, 0, 3, 3);
      expect_reject("R4");

      // extremes with valid gaps, then valid held while not ready: R2
      set_frame(1, 511, 1, 1, 1, 1, 1, 1, 1, 1, 1, 511);
      clear_counts();
      send_frame(1);
      in_valid = 1;
      in_data  = 9'd5;
      while (!in_ready) @(negedge clk);
      in_valid = 0;
      check(busy_cnt == 4 * 521, "R2", "busy cycles of gapped frame", busy_cnt, 2084);
      check(gate_cnt == 4 * 6, "R1", "gate cycles of gapped frame", gate_cnt, 24);

      set_frame(1, 2, 3, 1, 2, 6, 1, 3, 5, 2, 4, 300);
      clear_counts();
      send_frame(0);
      wait_idle();
      check(gate_cnt == 64, "R2", "gate cycles after ignored words", gate_cnt, 64);
      check(first_busy % SLOT == 0, "R6", "restart on slot", first_busy % SLOT, 0);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule